// File: doc/BRIEF.md
# Event Performance Counter Bank

This block holds a small set of 32-bit event counters that a processor's performance monitor reads and writes through a simple register bus. Each counter has its own configuration word. That word picks one of the event groups, masks that group's sub-event lines and filters counting by the core's current privilege level. A counter advances by one in any cycle where the masked group vector has at least one bit set and the privilege filter allows it. A single global enable gates every counter at once.

Software arms a sampling period by preloading a counter with the negative of the remaining count. When the counter rolls over from all ones to zero, a sticky overflow flag is set. If that counter has its interrupt enabled, the shared interrupt line is raised. One select code does not name an event group. Instead it makes the counter advance each time the counter just below it overflows, so two counters can be cascaded into a longer count.

Top module: `perf_counter_bank`

## Requirements
- R1: After reset every register reads zero and `irq` is low.
- R2: While bit 0 of the global register (offset 0x1000) is clear, no counter value changes except through a bus write. Bits 31:1 of that register read as zero.
- R3: A counter whose select field (config bits 12:8) names group g advances by exactly one in each cycle where `evt_in[g*16 +: 16]` ANDed with the mask (config bits 31:16) is non-zero. Sub-events outside the mask and other groups have no effect.
- R4: At privilege level 0 the privilege filter always passes. At a non-zero level it passes only when config bit 3 is set and the level is at most config bits 7:4. The filter applies to every counting source.
- R5: Select code 1 makes counter i advance once for each overflow of counter i-1, in the same cycle as that overflow. Counter 0 with select code 1 never advances.
- R6: When a counter steps from 0xFFFFFFFF to 0, its status bit 0 is set and stays set. Status bit 4 reads as status bit 0 ANDed with config bit 0 (interrupt enable).
- R7: Writing a status register clears bit 0 where the written bit 0 is one. A written zero leaves the flag unchanged.
- R8: `irq` is high exactly while some counter has both its overflow flag and its interrupt enable set. It stays high until software clears the flag.
- R9: Writing zero to a config register stops that counter and keeps its value.
- R10: A bus write to a counter value takes priority over an increment in the same cycle. That cycle causes no increment and no overflow.
- R11: Values sit at 0x1080+4i, config registers at 0x1100+4i and status registers at 0x1180+4i. Config reads return only bits 31:16, 12:4, 3 and 0. Unmapped offsets, and counter indices at or above the number of counters, read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| evt_in | input | NUM_GRP*16 | Sub-event lines, 16 per event group |
| priv_lvl | input | 4 | Current privilege level of the core, 0 for user |
| irq | output | 1 | Combined overflow interrupt |

## Verification
The assertions treat a cycle with `bus_wr` high as one where any register may legally jump. Their properties on counter steps, flag stickiness and interrupt hold are therefore conditioned on cycles with no write. They also assume that `bus_addr` and `bus_wdata` are valid whenever `bus_wr` is high and that `evt_in` and `priv_lvl` never carry unknown values. The stimulus changes every input only on falling clock edges, drives all inputs to known values from time zero, and lowers `bus_wr` after exactly one rising edge per write.

// File: rtl/pcb_pkg.sv
package pcb_pkg;
    localparam int CNT_W  = 32;
    localparam int MASK_W = 16;
    localparam int SEL_W  = 5;
    localparam int LVL_W  = 4;

    localparam logic [SEL_W-1:0] SEL_CHAIN = 5'd1;
    localparam int STA_OVF = 0;

    typedef struct packed {
        logic [MASK_W-1:0] mask;
        logic [SEL_W-1:0]  sel;
        logic [LVL_W-1:0]  lvl;
        logic              kern;
        logic              inten;
    } ctl_t;

    function automatic ctl_t ctl_from_word(logic [31:0] w);
        ctl_t c;
        c.mask  = w[31:16];
        c.sel   = w[12:8];
        c.lvl   = w[7:4];
        c.kern  = w[3];
        c.inten = w[0];
        return c;
    endfunction

    function automatic logic [31:0] ctl_to_word(ctl_t c);
        return {c.mask, 3'b000, c.sel, c.lvl, c.kern, 2'b00, c.inten};
    endfunction
endpackage

// File: rtl/pcb_event_match.sv
module pcb_event_match
    import pcb_pkg::*;
#(
    parameter int NUM_GRP = 32
) (
    input  ctl_t                      ctl,
    input  logic [NUM_GRP*MASK_W-1:0] evt,
    input  logic [LVL_W-1:0]          priv,
    output logic                      evt_hit,
    output logic                      priv_ok
);
    logic [MASK_W-1:0] grp;

    always_comb begin
        grp = '0;
        for (int g = 0; g < NUM_GRP; g++) begin
            if (ctl.sel == SEL_W'(g)) grp = evt[g*MASK_W +: MASK_W];
        end
        evt_hit = |(grp & ctl.mask);
        priv_ok = (priv == '0) || (ctl.kern && (priv <= ctl.lvl));
    end
endmodule

// File: rtl/pcb_counter.sv
module pcb_counter
    import pcb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic             evt_hit,
    input  logic             priv_ok,
    input  logic             chain_in,
    input  logic             we_val,
    input  logic             we_ctl,
    input  logic             we_sta,
    input  logic [31:0]      wdata,
    output logic [CNT_W-1:0] cnt_q,
    output ctl_t             ctl_q,
    output logic             ovf_q,
    output logic             wrap,
    output logic             irq
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        ctl_t             ctl;
        logic             ovf;
    } slice_t;

    slice_t st_d, st_q;
    logic   src, adv;

    always_comb begin
        src  = (st_q.ctl.sel == SEL_CHAIN) ? chain_in : evt_hit;
        adv  = cnt_en && priv_ok && src && !we_val;
        wrap = adv && (&st_q.cnt);
        st_d = st_q;
        if (we_val)   st_d.cnt = wdata;
        else if (adv) st_d.cnt = st_q.cnt + 1'b1;
        if (we_ctl)   st_d.ctl = ctl_from_word(wdata);
        st_d.ovf = (st_q.ovf && !(we_sta && wdata[STA_OVF])) || wrap;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_q = st_q.cnt;
    assign ctl_q = st_q.ctl;
    assign ovf_q = st_q.ovf;
    assign irq   = st_q.ovf && st_q.ctl.inten;
endmodule

// File: rtl/perf_counter_bank.sv
module perf_counter_bank
    import pcb_pkg::*;
#(
    parameter int NUM_CTR = 4,
    parameter int NUM_GRP = 32,
    parameter int ADDR_W  = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_wr,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic [31:0]               bus_wdata,
    output logic [31:0]               bus_rdata,
    input  logic [NUM_GRP*MASK_W-1:0] evt_in,
    input  logic [LVL_W-1:0]          priv_lvl,
    output logic                      irq
);
    localparam int WIN_LSB = 7;
    localparam int IDX_W   = WIN_LSB - 2;
    localparam logic [ADDR_W-1:0] GLOB_ADDR = ADDR_W'(32'h1000);
    localparam logic [ADDR_W-1:0] VAL_BASE  = ADDR_W'(32'h1080);
    localparam logic [ADDR_W-1:0] CTL_BASE  = ADDR_W'(32'h1100);
    localparam logic [ADDR_W-1:0] STA_BASE  = ADDR_W'(32'h1180);

    typedef struct packed {
        logic en;
    } glob_t;

    glob_t glob_d, glob_q;
    logic  glob_en;

    logic             in_val, in_ctl, in_sta, aligned;
    logic [IDX_W-1:0] idx;

    logic [CNT_W-1:0] val_w [NUM_CTR];
    logic [31:0]      cfg_w [NUM_CTR];
    logic [31:0]      sta_w [NUM_CTR];
    logic             wrap_w[NUM_CTR];
    logic [NUM_CTR-1:0] irq_w, ovf_all, wrap_all;
    logic [NUM_CTR*CNT_W-1:0] cnt_all;

    always_comb begin
        idx     = bus_addr[WIN_LSB-1:2];
        aligned = (bus_addr[1:0] == 2'b00);
        in_val  = aligned && (bus_addr[ADDR_W-1:WIN_LSB] == VAL_BASE[ADDR_W-1:WIN_LSB]);
        in_ctl  = aligned && (bus_addr[ADDR_W-1:WIN_LSB] == CTL_BASE[ADDR_W-1:WIN_LSB]);
        in_sta  = aligned && (bus_addr[ADDR_W-1:WIN_LSB] == STA_BASE[ADDR_W-1:WIN_LSB]);
        glob_d  = glob_q;
        if (bus_wr && bus_addr == GLOB_ADDR) glob_d.en = bus_wdata[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) glob_q <= '0;
        else        glob_q <= glob_d;
    end

    assign glob_en = glob_q.en;

    for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
        logic hit, pok, chain, ovf, cirq;
        ctl_t cfg;

        if (i == 0) begin : g_first
            assign chain = 1'b0;
        end else begin : g_next
            assign chain = wrap_w[i-1];
        end

        pcb_event_match #(.NUM_GRP(NUM_GRP)) u_match (
            .ctl     (cfg),
            .evt     (evt_in),
            .priv    (priv_lvl),
            .evt_hit (hit),
            .priv_ok (pok)
        );

        pcb_counter u_ctr (
            .clk      (clk),
            .rst_n    (rst_n),
            .cnt_en   (glob_q.en),
            .evt_hit  (hit),
            .priv_ok  (pok),
            .chain_in (chain),
            .we_val   (bus_wr && in_val && idx == IDX_W'(i)),
            .we_ctl   (bus_wr && in_ctl && idx == IDX_W'(i)),
            .we_sta   (bus_wr && in_sta && idx == IDX_W'(i)),
            .wdata    (bus_wdata),
            .cnt_q    (val_w[i]),
            .ctl_q    (cfg),
            .ovf_q    (ovf),
            .wrap     (wrap_w[i]),
            .irq      (cirq)
        );

        assign cfg_w[i]    = ctl_to_word(cfg);
        assign sta_w[i]    = {27'b0, cirq, 3'b000, ovf};
        assign irq_w[i]    = cirq;
        assign ovf_all[i]  = ovf;
        assign wrap_all[i] = wrap_w[i];
        assign cnt_all[i*CNT_W +: CNT_W] = val_w[i];
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == GLOB_ADDR) bus_rdata = {31'b0, glob_q.en};
        for (int i = 0; i < NUM_CTR; i++) begin
            if (idx == IDX_W'(i)) begin
                if (in_val) bus_rdata = val_w[i];
                if (in_ctl) bus_rdata = cfg_w[i];
                if (in_sta) bus_rdata = sta_w[i];
            end
        end
    end

    assign irq = |irq_w;
endmodule

// File: rtl/pcb_checker.sv
module pcb_checker #(
    parameter int NUM_CTR = 4,
    parameter int ADDR_W  = 16
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  bus_wr,
    input logic [ADDR_W-1:0]     bus_addr,
    input logic [31:0]           bus_wdata,
    input logic                  irq,
    input logic                  glob_en,
    input logic [NUM_CTR*32-1:0] cnt_all,
    input logic [NUM_CTR-1:0]    ovf_all,
    input logic [NUM_CTR-1:0]    wrap_all
);
    // R2: with the global enable clear and no write, all values hold
    a_r2_gate_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!glob_en && !bus_wr) |=> $stable(cnt_all));

    // R8: the interrupt cannot drop without a bus write
    a_r8_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !bus_wr) |=> irq);

    for (genvar i = 0; i < NUM_CTR; i++) begin : g_chk
        localparam logic [ADDR_W-1:0] VADDR = ADDR_W'(32'h1080 + 4*i);

        // R3: without a write a value holds or steps by exactly one
        a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_n)
            !bus_wr |=> (cnt_all[i*32 +: 32] == $past(cnt_all[i*32 +: 32])) ||
                        (cnt_all[i*32 +: 32] == $past(cnt_all[i*32 +: 32]) + 32'd1));

        // R6: a rollover always sets the flag
        a_r6_wrap_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
            wrap_all[i] |=> ovf_all[i]);

        // R7: the flag is sticky while no write occurs
        a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (ovf_all[i] && !bus_wr) |=> ovf_all[i]);

        // R10: a value write lands exactly, whatever the events did
        a_r10_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && bus_addr == VADDR) |=> (cnt_all[i*32 +: 32] == $past(bus_wdata)));
    end
endmodule

bind perf_counter_bank pcb_checker #(.NUM_CTR(NUM_CTR), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .irq       (irq),
    .glob_en   (glob_en),
    .cnt_all   (cnt_all),
    .ovf_all   (ovf_all),
    .wrap_all  (wrap_all)
);

// File: tb/perf_counter_bank_test.sv
module perf_counter_bank_test;
    localparam int NC = 4;
    localparam int NG = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic [15:0]   bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NG*16-1:0] evt = '0;
    logic [3:0]    priv = '0;
    logic          irq;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    perf_counter_bank #(.NUM_CTR(NC), .NUM_GRP(NG), .ADDR_W(16)) uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_in(evt),
        .priv_lvl(priv), .irq(irq)
    );

    function automatic logic [15:0] va(int i); return 16'(32'h1080 + 4*i); endfunction
    function automatic logic [15:0] ca(int i); return 16'(32'h1100 + 4*i); endfunction
    function automatic logic [15:0] sa(int i); return 16'(32'h1180 + 4*i); endfunction
    function automatic logic [31:0] cw(int sel, logic [15:0] mask, bit kern, int lvl, bit inten);
        return {mask, 3'b000, 5'(sel), 4'(lvl), kern, 2'b00, inten};
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wr(logic [15:0] a, logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [15:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic pulse(int g, int b, int n);
        evt = '0;
        evt[g*16 + b] = 1'b1;
        repeat (n) @(negedge clk);
        evt = '0;
    endtask

    task automatic t_reset;
        logic [31:0] d;
        rd(16'h1000, d); chk("R1", "global", d, 0);
        for (int i = 0; i < NC; i++) begin
            rd(va(i), d); chk("R1", "value", d, 0);
        end
        rd(ca(0), d); chk("R1", "config0", d, 0);
        rd(sa(0), d); chk("R1", "status0", d, 0);
        chk("R1", "irq", 32'(irq), 0);
    endtask

    task automatic t_map;
        logic [31:0] d;
        wr(16'h1000, 32'hFFFF_FFFF);
        rd(16'h1000, d); chk("R11", "global readback", d, 1);
        wr(ca(3), 32'hFFFF_FFFF);
        rd(ca(3), d); chk("R11", "config field mask", d, 32'hFFFF_1FF9);
        wr(ca(3), 0);
        rd(16'h1004, d); chk("R11", "unmapped 0x1004", d, 0);
        rd(16'h1090, d); chk("R11", "index beyond bank", d, 0);
        rd(16'h1200, d); chk("R11", "unmapped 0x1200", d, 0);
    endtask

    task automatic t_count;
        logic [31:0] d;
        wr(va(0), 0);
        wr(ca(0), cw(5, 16'h0006, 0, 0, 0));
        pulse(5, 2, 7);
        rd(va(0), d); chk("R3", "masked bit counts", d, 7);
        pulse(5, 0, 4);
        rd(va(0), d); chk("R3", "unmasked bit ignored", d, 7);
        pulse(6, 2, 4);
        rd(va(0), d); chk("R3", "other group ignored", d, 7);
        pulse(5, 1, 3);
        rd(va(0), d); chk("R3", "second masked bit", d, 10);
    endtask

    task automatic t_gate;
        logic [31:0] d;
        wr(16'h1000, 0);
        pulse(5, 1, 5);
        rd(va(0), d); chk("R2", "global off holds", d, 10);
        wr(16'h1000, 1);
    endtask

    task automatic t_priv;
        logic [31:0] d;
        wr(va(1), 0);
        wr(ca(1), cw(9, 16'h0001, 1, 2, 0));
        priv = 4'd3; pulse(9, 0, 4);
        rd(va(1), d); chk("R4", "level above threshold", d, 0);
        priv = 4'd2; pulse(9, 0, 4);
        rd(va(1), d); chk("R4", "level at threshold", d, 4);
        wr(ca(1), cw(9, 16'h0001, 0, 15, 0));
        priv = 4'd1; pulse(9, 0, 4);
        rd(va(1), d); chk("R4", "privileged counting off", d, 4);
        priv = 4'd0; pulse(9, 0, 3);
        rd(va(1), d); chk("R4", "user level always", d, 7);
    endtask

    task automatic t_chain;
        logic [31:0] d;
        wr(va(0), 32'hFFFF_FFFE);
        wr(ca(0), cw(5, 16'h0001, 0, 0, 0));
        wr(va(1), 0);
        wr(ca(1), cw(1, 16'h0000, 0, 0, 0));
        pulse(5, 0, 3);
        rd(va(0), d); chk("R6", "wrapped value", d, 1);
        rd(va(1), d); chk("R5", "chained count", d, 1);
        rd(sa(0), d); chk("R6", "flag without enable", d, 32'h1);
        rd(sa(1), d); chk("R5", "chained no flag", d, 0);
        chk("R8", "irq disabled", 32'(irq), 0);
        wr(ca(0), cw(1, 16'hFFFF, 0, 0, 0));
        wr(va(0), 5);
        evt = '1; repeat (4) @(negedge clk); evt = '0;
        rd(va(0), d); chk("R5", "counter0 chain idle", d, 5);
        rd(va(1), d); chk("R5", "no extra chain step", d, 1);
        wr(ca(0), cw(5, 16'h0001, 0, 0, 1));
        rd(sa(0), d); chk("R6", "flag with enable", d, 32'h11);
        chk("R8", "irq raised", 32'(irq), 1);
    endtask

    task automatic t_clear;
        logic [31:0] d;
        repeat (5) @(negedge clk);
        chk("R8", "irq held", 32'(irq), 1);
        wr(sa(0), 0);
        rd(sa(0), d); chk("R7", "zero write keeps flag", d, 32'h11);
        wr(sa(0), 1);
        rd(sa(0), d); chk("R7", "one write clears", d, 0);
        chk("R8", "irq dropped", 32'(irq), 0);
    endtask

    task automatic t_stop;
        logic [31:0] d;
        wr(va(0), 100);
        pulse(5, 0, 2);
        rd(va(0), d); chk("R9", "running", d, 102);
        wr(ca(0), 0);
        pulse(5, 0, 5);
        rd(va(0), d); chk("R9", "stopped keeps value", d, 102);
    endtask

    task automatic t_race;
        logic [31:0] d;
        wr(ca(2), cw(7, 16'h0001, 0, 0, 1));
        wr(va(2), 32'hFFFF_FFF0);
        @(negedge clk);
        evt[7*16] = 1'b1;
        bus_wr = 1'b1; bus_addr = va(2); bus_wdata = 32'hFFFF_FFFF;
        @(negedge clk);
        bus_wr = 1'b0; evt = '0;
        rd(va(2), d); chk("R10", "write beats increment", d, 32'hFFFF_FFFF);
        rd(sa(2), d); chk("R10", "no overflow on write", d, 0);
        pulse(7, 0, 1);
        rd(va(2), d); chk("R6", "rollover to zero", d, 0);
        rd(sa(2), d); chk("R6", "flag and irq bit", d, 32'h11);
        chk("R8", "irq from counter2", 32'(irq), 1);
        wr(sa(2), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_map();
        t_count();
        t_gate();
        t_priv();
        t_chain();
        t_clear();
        t_stop();
        t_race();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        #1_000_000;
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule